// File: doc/BRIEF.md
# One-Wire Device-ID Search Sequencer

This block drives one pass of the 64-bit device-ID search on a one-wire bus. Each pass opens with a bus reset, then shifts out the search command 0xF0 one bit at a time, least significant bit first. After that it walks the 64 ID bit positions in turn. At each position it reads the bit that all selected devices put on the wired-AND bus, then reads the complement of that bit. From the two reads it picks a branch direction and writes that direction back, so that devices whose ID disagrees drop out of the search.

A caller lists every device on the bus by repeating the search. The first pass starts with a previous-discrepancy value of 0. Each later pass feeds back the new discrepancy index that the block returned, until that index comes back as 0. The ID register keeps its contents between passes. At positions below the previous discrepancy, the branch repeats the direction taken in the last pass. The bus timing itself is not part of this block. Every slot is a request/acknowledge exchange with a separate slot engine.

The controller has seven states. IDLE goes to BUS_RST on `start`. BUS_RST goes to CMD on acknowledge. CMD goes to RD_TRUE after the eighth command slot. RD_TRUE goes to RD_CMPL on acknowledge. RD_CMPL goes to WR_DIR on a valid pair of reads, or to FINISH when both reads are 1. WR_DIR goes back to RD_TRUE for the next position, or to FINISH after position 63. FINISH always returns to IDLE.

Top module: `ow_rom_search`

## Requirements
- R1: A pass issues a reset slot first, then eight write slots carrying 0xF0, least significant bit first. Slot codes on `slot_op` are 0 = bus reset, 1 = read one bit, 2 = write 0, 3 = write 1.
- R2: For each position 0..63 in ascending order the block issues a read slot (true bit), a read slot (complement), then one write slot. A full pass is therefore 201 slots.
- R3: If both reads of a position return 1, the pass ends at once. It ends with `fail` = 1, `new_disc` = 0, a `done` pulse and no further slot.
- R4: If the two reads differ, ID bit `idx` takes the value of the first read, and that value is written to the bus.
- R5: If both reads are 0 and `idx` equals `prev_disc`, the bit is set to 1 and written.
- R6: If both reads are 0 and `idx` is greater than `prev_disc`, the bit is set to 0 and `idx` is recorded as the new discrepancy.
- R7: If both reads are 0 and `idx` is less than `prev_disc`, the bit keeps the value it held after the previous pass. If that value is 0, `idx` is recorded as the new discrepancy.
- R8: `new_disc` reports the last index recorded during the pass, or 0 if no index was recorded.
- R9: `rom_id` holds its value while the block is idle and from one pass to the next.
- R10: `done` is high for exactly one cycle after the last slot of a pass. `rom_id`, `new_disc` and `fail` are valid in that cycle. `busy` is high from the cycle after `start` until `done`.
- R11: Once raised, `slot_req` stays high with a constant `slot_op` until the cycle in which `slot_ack` is seen.
- R12: After reset, `busy`, `done`, `fail` and `slot_req` are 0, and `rom_id` and `new_disc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a pass when idle |
| prev_disc | input | 6 | Discrepancy index returned by the previous pass |
| slot_req | output | 1 | Slot request to the slot engine |
| slot_op | output | 2 | Slot code (see R1) |
| slot_ack | input | 1 | One-cycle completion of the current slot |
| slot_rbit | input | 1 | Bus value sampled by a read slot, valid with `slot_ack` |
| rom_id | output | 64 | ID assembled by the search |
| new_disc | output | 6 | Discrepancy index for the next pass |
| fail | output | 1 | Pass aborted because both reads returned 1 |
| done | output | 1 | One-cycle end-of-pass pulse |
| busy | output | 1 | Pass in progress |

## Verification
The bound checker watches the following on every cycle:
- the slot request staying stable until its acknowledge;
- `done` lasting exactly one cycle, with the bus quiet in that cycle;
- a failed pass always reporting discrepancy 0;
- every pass opening with a reset slot;
- the ID register staying frozen while idle.

The branch rules and the command byte can only be shown by the bench scenarios. A bus model with several devices checks each slot against the expected order and wired-AND response. The rules R5 to R8 are covered by running a full enumeration, where each pass depends on the ID retained from the pass before, and by injecting an illegal read pair partway through a pass.

// File: rtl/ow_search_pkg.sv
package ow_search_pkg;

    typedef enum logic [1:0] {
        SLOT_RESET = 2'd0,
        SLOT_READ  = 2'd1,
        SLOT_WR0   = 2'd2,
        SLOT_WR1   = 2'd3
    } slot_op_t;

    typedef enum logic [2:0] {
        IDLE    = 3'd0,
        BUS_RST = 3'd1,
        CMD     = 3'd2,
        RD_TRUE = 3'd3,
        RD_CMPL = 3'd4,
        WR_DIR  = 3'd5,
        FINISH  = 3'd6
    } srch_state_t;

endpackage

// File: rtl/ows_step_counter.sv
module ows_step_counter #(
    parameter int W    = 3,
    parameter int LAST = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count_q,
    output logic         at_last
);
    localparam logic [W-1:0] LAST_V = W'(LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (clr)
            count_q <= '0;
        else if (inc)
            count_q <= count_q + 1'b1;
    end

    assign at_last = (count_q == LAST_V);
endmodule

// File: rtl/ows_branch.sv
module ows_branch #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] last_disc,
    input  logic             rd_true,
    input  logic             rd_cmpl,
    input  logic             prev_bit,
    output logic             abort,
    output logic             dir_bit,
    output logic             mark_disc
);
    always_comb begin
        abort     = 1'b0;
        dir_bit   = rd_true;
        mark_disc = 1'b0;
        if (rd_true && rd_cmpl) begin
            abort = 1'b1;
        end else if (!rd_true && !rd_cmpl) begin
            if (idx == last_disc) begin
                dir_bit = 1'b1;
            end else if (idx > last_disc) begin
                dir_bit   = 1'b0;
                mark_disc = 1'b1;
            end else begin
                dir_bit   = prev_bit;
                mark_disc = ~prev_bit;
            end
        end
    end
endmodule

// File: rtl/ows_id_reg.sv
module ows_id_reg #(
    parameter int ID_W  = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    output logic [ID_W-1:0]  id_q
);
    for (genvar g = 0; g < ID_W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                id_q[g] <= 1'b0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                id_q[g] <= wr_bit;
        end
    end
endmodule

// File: rtl/ow_rom_search.sv
module ow_rom_search
    import ow_search_pkg::*;
#(
    parameter int          ID_W     = 64,
    parameter logic [7:0]  CMD_BYTE = 8'hF0,
    localparam int         IDX_W    = $clog2(ID_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] prev_disc,
    output logic             slot_req,
    output logic [1:0]       slot_op,
    input  logic             slot_ack,
    input  logic             slot_rbit,
    output logic [ID_W-1:0]  rom_id,
    output logic [IDX_W-1:0] new_disc,
    output logic             fail,
    output logic             done,
    output logic             busy
);
    srch_state_t state_q, state_d;

    logic [2:0]       cmd_idx;
    logic             cmd_last;
    logic [IDX_W-1:0] idx;
    logic             idx_last;
    logic             a_q;
    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] disc_q;
    logic             fail_q;
    logic             abort, dir_bit, mark_disc;
    logic             go;
    logic             decide;
    logic             cmd_step, idx_step;

    assign go       = (state_q == IDLE) && start;
    assign decide   = (state_q == RD_CMPL) && slot_ack;
    assign cmd_step = (state_q == CMD) && slot_ack;
    assign idx_step = (state_q == WR_DIR) && slot_ack && !idx_last;

    ows_step_counter #(.W(3), .LAST(7)) u_cmd_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (go),
        .inc     (cmd_step),
        .count_q (cmd_idx),
        .at_last (cmd_last)
    );

    ows_step_counter #(.W(IDX_W), .LAST(ID_W-1)) u_idx_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (go),
        .inc     (idx_step),
        .count_q (idx),
        .at_last (idx_last)
    );

    ows_branch #(.IDX_W(IDX_W)) u_branch (
        .idx       (idx),
        .last_disc (last_q),
        .rd_true   (a_q),
        .rd_cmpl   (slot_rbit),
        .prev_bit  (rom_id[idx]),
        .abort     (abort),
        .dir_bit   (dir_bit),
        .mark_disc (mark_disc)
    );

    ows_id_reg #(.ID_W(ID_W), .IDX_W(IDX_W)) u_id (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (decide && !abort),
        .wr_idx (idx),
        .wr_bit (dir_bit),
        .id_q   (rom_id)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE:    if (start) state_d = BUS_RST;
            BUS_RST: if (slot_ack) state_d = CMD;
            CMD:     if (slot_ack && cmd_last) state_d = RD_TRUE;
            RD_TRUE: if (slot_ack) state_d = RD_CMPL;
            RD_CMPL: if (slot_ack) state_d = abort ? FINISH : WR_DIR;
            WR_DIR:  if (slot_ack) state_d = idx_last ? FINISH : RD_TRUE;
            FINISH:  state_d = IDLE;
            default: state_d = IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= 1'b0;
            last_q <= '0;
            disc_q <= '0;
            fail_q <= 1'b0;
        end else if (go) begin
            last_q <= prev_disc;
            disc_q <= '0;
            fail_q <= 1'b0;
        end else begin
            if ((state_q == RD_TRUE) && slot_ack)
                a_q <= slot_rbit;
            if (decide && abort) begin
                fail_q <= 1'b1;
                disc_q <= '0;
            end else if (decide && mark_disc) begin
                disc_q <= idx;
            end
        end
    end

    // outputs
    always_comb begin
        slot_req = 1'b0;
        slot_op  = SLOT_RESET;
        unique case (state_q)
            BUS_RST: begin
                slot_req = 1'b1;
                slot_op  = SLOT_RESET;
            end
            CMD: begin
                slot_req = 1'b1;
                slot_op  = CMD_BYTE[cmd_idx] ? SLOT_WR1 : SLOT_WR0;
            end
            RD_TRUE, RD_CMPL: begin
                slot_req = 1'b1;
                slot_op  = SLOT_READ;
            end
            WR_DIR: begin
                slot_req = 1'b1;
                slot_op  = rom_id[idx] ? SLOT_WR1 : SLOT_WR0;
            end
            IDLE, FINISH: begin
                slot_req = 1'b0;
                slot_op  = SLOT_RESET;
            end
            default: begin
                slot_req = 1'b0;
                slot_op  = SLOT_RESET;
            end
        endcase
    end

    assign done     = (state_q == FINISH);
    assign busy     = (state_q != IDLE);
    assign fail     = fail_q;
    assign new_disc = disc_q;
endmodule

// File: rtl/ow_rom_search_chk.sv
module ow_rom_search_chk #(
    parameter int ID_W  = 64,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             slot_req,
    input logic [1:0]       slot_op,
    input logic             slot_ack,
    input logic [ID_W-1:0]  rom_id,
    input logic [IDX_W-1:0] new_disc,
    input logic             fail,
    input logic             done,
    input logic             busy
);
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req && !slot_ack |=> slot_req && $stable(slot_op));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !slot_req);

    assert_fail_disc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done && fail |-> new_disc == '0);

    assert_first_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> slot_req && slot_op == 2'd0);

    assert_hold_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(rom_id));
endmodule

bind ow_rom_search ow_rom_search_chk #(.ID_W(ID_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .slot_req (slot_req),
    .slot_op  (slot_op),
    .slot_ack (slot_ack),
    .rom_id   (rom_id),
    .new_disc (new_disc),
    .fail     (fail),
    .done     (done),
    .busy     (busy)
);

// File: tb/ow_rom_search_bench.sv
module ow_rom_search_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 9;
    localparam logic [7:0] CMD = 8'hF0;
    localparam logic [63:0] DEV [4] = '{64'h01, 64'h03, 64'h11, 64'h13};

    typedef struct packed {
        logic [3:0]  mask;
        logic [5:0]  prev;
        logic [6:0]  fault;     // 127 = no fault
        logic [63:0] exp_id;
        logic [5:0]  exp_disc;
        logic        exp_fail;
    } vec_t;

    // rows run in order: each pass relies on the ID kept from the one before
    localparam vec_t VECS [NVEC] = '{
        '{4'h3, 6'd0, 7'd127, 64'h01, 6'd1, 1'b0},  // R6
        '{4'h3, 6'd1, 7'd127, 64'h03, 6'd0, 1'b0},  // R5
        '{4'hF, 6'd0, 7'd127, 64'h01, 6'd4, 1'b0},  // R6 R8
        '{4'hF, 6'd4, 7'd127, 64'h11, 6'd1, 1'b0},  // R7 keep 0, recorded
        '{4'hF, 6'd1, 7'd127, 64'h03, 6'd4, 1'b0},  // R5 R6
        '{4'hF, 6'd4, 7'd127, 64'h13, 6'd0, 1'b0},  // R7 keep 1, not recorded
        '{4'h4, 6'd7, 7'd127, 64'h11, 6'd0, 1'b0},  // R4
        '{4'h0, 6'd5, 7'd127, 64'h00, 6'd0, 1'b1},  // R3 empty bus
        '{4'hF, 6'd0, 7'd10,  64'h00, 6'd0, 1'b1}   // R3 fault after discrepancies
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  prev_disc = '0;
    logic        slot_req;
    logic [1:0]  slot_op;
    logic        slot_ack;
    logic        slot_rbit;
    logic [63:0] rom_id;
    logic [5:0]  new_disc;
    logic        fail, done, busy;

    int checks = 0;
    int errors = 0;
    logic [3:0] cur_mask = '0;
    int         fault_pos = 127;
    int         cmd_err = 0;
    int         seq_err = 0;
    int         slot_cnt = 0;
    bit         finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ow_rom_search u_ow_rom_search (
        .clk(clk), .rst_n(rst_n), .start(start), .prev_disc(prev_disc),
        .slot_req(slot_req), .slot_op(slot_op), .slot_ack(slot_ack),
        .slot_rbit(slot_rbit), .rom_id(rom_id), .new_disc(new_disc),
        .fail(fail), .done(done), .busy(busy)
    );

    // bus model: wired-AND of the still-selected devices
    initial begin
        logic [3:0] active;
        int step;
        active = '0;
        step = 0;
        slot_ack = 1'b0;
        slot_rbit = 1'b0;
        forever begin
            @(posedge clk);
            if (slot_ack) begin
                slot_ack <= 1'b0;
            end else if (slot_req) begin
                slot_ack <= 1'b1;
                slot_cnt++;
                if (slot_op == 2'd0) begin
                    active = cur_mask;
                    step = 0;
                    slot_cnt = 1;
                end else if (step < 8) begin
                    if (slot_op != {1'b1, CMD[step]}) cmd_err++;
                    step++;
                end else begin
                    int pos, sub;
                    logic r;
                    pos = (step - 8) / 3;
                    sub = (step - 8) % 3;
                    if (sub < 2) begin
                        if (slot_op != 2'd1) seq_err++;
                        r = 1'b1;
                        for (int k = 0; k < 4; k++)
                            if (active[k] && (DEV[k][pos] == (sub == 1))) r = 1'b0;
                        if (pos == fault_pos) r = 1'b1;
                        slot_rbit <= r;
                    end else begin
                        if (!slot_op[1]) seq_err++;
                        for (int k = 0; k < 4; k++)
                            if (DEV[k][pos] != slot_op[0]) active[k] = 1'b0;
                    end
                    step++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic run_search(input logic [3:0] mask, input logic [5:0] prev,
                              input int fpos);
        int t;
        cur_mask = mask;
        fault_pos = fpos;
        @(negedge clk);
        prev_disc = prev;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R10 busy", {63'd0, busy}, 64'd1);
        t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(done, "R10 done seen", {63'd0, done}, 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R12 reset state
        check(!busy && !done && !fail, "R12 flags", {61'd0, busy, done, fail}, 64'd0);
        check(!slot_req, "R12 slot_req", {63'd0, slot_req}, 64'd0);
        check(rom_id == 0 && new_disc == 0, "R12 outputs", rom_id, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            run_search(VECS[v].mask, VECS[v].prev, int'(VECS[v].fault));
            check(fail == VECS[v].exp_fail, "R3 fail flag", {63'd0, fail},
                  {63'd0, VECS[v].exp_fail});
            check(new_disc == VECS[v].exp_disc, "R8 new_disc", {58'd0, new_disc},
                  {58'd0, VECS[v].exp_disc});
            if (!VECS[v].exp_fail)
                check(rom_id == VECS[v].exp_id, "R4 R5 R6 R7 rom_id", rom_id,
                      VECS[v].exp_id);
            if (!VECS[v].exp_fail)
                check(slot_cnt == 201, "R2 slot count", 64'(slot_cnt), 64'd201);
            else if (VECS[v].mask == 4'h0)
                check(slot_cnt == 11, "R3 no slot after abort", 64'(slot_cnt), 64'd11);
            @(negedge clk);
            check(!done, "R10 done one cycle", {63'd0, done}, 64'd0);
        end

        check(cmd_err == 0, "R1 command byte", 64'(cmd_err), 64'd0);
        check(seq_err == 0, "R2 slot order", 64'(seq_err), 64'd0);

        // R9: retained through idle, then reused by the keep rule
        run_search(4'hF, 6'd0, 127);
        held = rom_id;
        repeat (50) @(negedge clk);
        check(rom_id == held && rom_id == 64'h01, "R9 hold while idle", rom_id, 64'h01);
        run_search(4'hF, 6'd4, 127);
        check(rom_id == 64'h11 && new_disc == 6'd1, "R7 R9 keep after idle", rom_id,
              64'h11);

        finish_run();
    end
endmodule